// File: doc/BRIEF.md
# Event Timer with Compare and Capture

This block is a 16-bit up-counter for a larger chip. It advances by one on every cycle in which a one-cycle tick enable is high, so any prescaler or divider sits outside it. The counter raises three kinds of event. An overflow event occurs when it wraps from its top value. A compare event occurs when it equals a programmed compare value. A capture event occurs when a qualified edge on an input pin copies the live count into a capture register. A compare match can also drive a waveform pin, and an optional mode restarts the count from zero on a match.

Each event sets a sticky flag. Software clears a flag by writing one to its bit. A mask selects which flags reach the single interrupt line. Software uses a flat register port: one write strobe with an address and data, and a combinational read mux on a separate read address.

The capture path passes the pin through a two-flop synchronizer. A two-state qualifier machine follows it. In state SETTLED, the synchronized level equals the accepted level. When the level differs and the filter is on, the machine moves to PENDING. PENDING counts consecutive differing samples. It returns to SETTLED when the level falls back to the accepted level or when it accepts the change. With the filter off, a differing sample is accepted directly from SETTLED.

Top module: `evt_timer`

Register addresses:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 clear-on-match, bits 2:1 wave mode, bit 3 falling-edge select, bit 4 filter enable |
| 1 | Count |
| 2 | Compare |
| 3 | Capture (read only) |
| 4 | Flags: bit 0 overflow, bit 1 compare, bit 2 capture |
| 5 | Mask, with the same bit positions as the flags |

Unused addresses read zero.

## Requirements
- R1: With no count write, the count rises by exactly one on each cycle with tick high and holds while tick is low.
- R2: A tick while the count is 0xFFFF returns it to 0 and sets flag bit 0 (overflow).
- R3: A tick while the count equals the compare register sets flag bit 1 (compare).
- R4: With control bit 0 set, a tick on a compare match loads 0 instead of count+1.
- R5: On a compare event, control bits 2:1 act on the waveform state: 01 toggles it, 10 clears it, 11 sets it. With 00 the waveform state is unchanged and the wave output reads low.
- R6: The capture pin passes two synchronizer flops. An accepted change of the sampled level in the active direction copies the count into the capture register and sets flag bit 2. Control bit 3 = 0 selects rising edges and 1 selects falling edges.
- R7: With control bit 4 set, a level change is accepted only after four consecutive differing samples. Shorter pulses are ignored.
- R8: Writing address 4 clears each flag whose data bit is one. Flags with zero data bits keep their value.
- R9: When a flag is set by hardware and cleared by software in the same cycle, it ends up set.
- R10: The interrupt output is high exactly when some flag and its mask bit (address 5) are both one.
- R11: A write to address 1 loads the count. Any tick in that same cycle is discarded and raises no event.
- R12: After reset, every register reads zero and the wave and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable for one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach is a filtered capture pulse that ends just short of, or just at, the four-sample threshold. Random pin activity seldom lines up with that boundary while the flags are being watched. The stimulus drives the boundary directly: a two-cycle glitch that must leave the capture flag clear, then a long pulse that must capture. A full reference model also runs against thousands of random cycles. In those cycles, count writes land next to the compare value and near the top of the range, so matches and wraps occur often and sometimes coincide with flag clears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int N_EVT = 3;
    localparam int EV_OVF = 0;
    localparam int EV_CMP = 1;
    localparam int EV_CAP = 2;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_COUNT = 3'd1;
    localparam logic [2:0] A_CMP   = 3'd2;
    localparam logic [2:0] A_CAPT  = 3'd3;
    localparam logic [2:0] A_FLAGS = 3'd4;
    localparam logic [2:0] A_MASK  = 3'd5;

    typedef enum logic [1:0] {
        WAVE_OFF    = 2'b00,
        WAVE_TOGGLE = 2'b01,
        WAVE_CLEAR  = 2'b10,
        WAVE_SET    = 2'b11
    } wave_mode_e;

    typedef enum logic {
        Q_SETTLED = 1'b0,
        Q_PENDING = 1'b1
    } qual_state_e;

    typedef struct packed {
        logic       filt_en;
        logic       fall_edge;
        wave_mode_e wave_mode;
        logic       clr_on_match;
    } ctrl_t;
endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_on_match_i,
    input  wave_mode_e       wave_mode_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             ovf_evt_o,
    output logic             cmp_evt_o,
    output logic             wave_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q;
    logic             wave_q;
    logic             step_en;

    assign step_en   = tick_i & ~cnt_wr_i;
    assign ovf_evt_o = step_en && (cnt_q == CNT_MAX);
    assign cmp_evt_o = step_en && (cnt_q == cmp_q);

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr_i)
            cnt_d = wdata_i;
        else if (step_en) begin
            if (clr_on_match_i && cmp_evt_o)
                cnt_d = '0;
            else
                cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmp_wr_i)
                cmp_q <= wdata_i;
            if (cmp_evt_o) begin
                unique case (wave_mode_i)
                    WAVE_TOGGLE: wave_q <= ~wave_q;
                    WAVE_CLEAR:  wave_q <= 1'b0;
                    WAVE_SET:    wave_q <= 1'b1;
                    WAVE_OFF:    wave_q <= wave_q;
                endcase
            end
        end
    end

    assign count_o = cnt_q;
    assign cmp_o   = cmp_q;
    assign wave_o  = (wave_mode_i != WAVE_OFF) && wave_q;

    // R1: plain step
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && cnt_q != CNT_MAX && !(clr_on_match_i && cnt_q == cmp_q))
        |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    // R2: wrap to zero
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && cnt_q == CNT_MAX) |=> cnt_q == '0);
    // R4: restart on match
    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && clr_on_match_i && cnt_q == cmp_q) |=> cnt_q == '0);
    // R5: set mode drives the pin high
    a_r5_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt_o && wave_mode_i == WAVE_SET) |=> wave_q);
    // R11: a load wins over a tick
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/tmr_cap_unit.sv
module tmr_cap_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             filt_en_i,
    input  logic             fall_edge_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] capt_o,
    output logic             cap_evt_o
);
    localparam int RUN_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    logic             s1_q, s2_q, lvl_q;
    qual_state_e      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [CNT_W-1:0] capt_q;
    logic             differ, accept;

    assign differ    = s2_q ^ lvl_q;
    assign accept    = differ && (!filt_en_i || run_q == RUN_LAST);
    assign cap_evt_o = accept && (fall_edge_i ? !s2_q : s2_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_SETTLED;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            Q_SETTLED: begin
                if (differ && !accept) begin
                    state_d = Q_PENDING;
                    run_d   = RUN_W'(1);
                end else
                    run_d = '0;
            end
            Q_PENDING: begin
                if (!differ || accept) begin
                    state_d = Q_SETTLED;
                    run_d   = '0;
                end else
                    run_d = run_q + RUN_W'(1);
            end
        endcase
    end

    // outputs: synchronizer, accepted level, capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            lvl_q  <= 1'b0;
            capt_q <= '0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            if (accept)
                lvl_q <= s2_q;
            if (cap_evt_o)
                capt_q <= count_i;
        end
    end

    assign capt_o = capt_q;

    // R6: captured value is the count seen with the event
    a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |=> capt_q == $past(count_i));

    generate
        if (FILT_LEN > 1) begin : g_filt_chk
            // R7: a filtered acceptance follows a steady sample
            a_r7_filter_steady: assert property (@(posedge clk) disable iff (!rst_n)
                (filt_en_i && $past(filt_en_i) && accept) |-> ($past(s2_q) == s2_q));
        end
    endgenerate
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_data_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] flags_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
            if (mask_wr_i)
                mask_q <= mask_data_i;
        end
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(flags_q & mask_q);

    // R9: hardware set beats software clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
    // R8: flags only fall through a write of one
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_q) |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [2:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    input  logic             cap_pin_i,
    output logic             wave_o,
    output logic             irq_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] count, cmp_val, capt;
    logic             ovf_evt, cmp_evt, cap_evt;
    logic [N_EVT-1:0] flags, mask, set_vec, clr_vec;
    logic             wr_ctrl, wr_cnt, wr_cmp, wr_flags, wr_mask;

    assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_cnt   = wr_en_i && (wr_addr_i == A_COUNT);
    assign wr_cmp   = wr_en_i && (wr_addr_i == A_CMP);
    assign wr_flags = wr_en_i && (wr_addr_i == A_FLAGS);
    assign wr_mask  = wr_en_i && (wr_addr_i == A_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end

    tmr_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .cnt_wr_i       (wr_cnt),
        .cmp_wr_i       (wr_cmp),
        .wdata_i        (wr_data_i),
        .clr_on_match_i (ctrl_q.clr_on_match),
        .wave_mode_i    (ctrl_q.wave_mode),
        .count_o        (count),
        .cmp_o          (cmp_val),
        .ovf_evt_o      (ovf_evt),
        .cmp_evt_o      (cmp_evt),
        .wave_o         (wave_o)
    );

    tmr_cap_unit #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (cap_pin_i),
        .filt_en_i   (ctrl_q.filt_en),
        .fall_edge_i (ctrl_q.fall_edge),
        .count_i     (count),
        .capt_o      (capt),
        .cap_evt_o   (cap_evt)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[EV_OVF] = ovf_evt;
        set_vec[EV_CMP] = cmp_evt;
        set_vec[EV_CAP] = cap_evt;
    end
    assign clr_vec = wr_flags ? wr_data_i[N_EVT-1:0] : '0;

    tmr_flag_bank #(.N(N_EVT)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_vec),
        .clr_i       (clr_vec),
        .mask_wr_i   (wr_mask),
        .mask_data_i (wr_data_i[N_EVT-1:0]),
        .flags_o     (flags),
        .mask_o      (mask),
        .irq_o       (irq_o)
    );

    always_comb begin
        unique case (rd_addr_i)
            A_CTRL:  rd_data_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            A_COUNT: rd_data_o = count;
            A_CMP:   rd_data_o = cmp_val;
            A_CAPT:  rd_data_o = capt;
            A_FLAGS: rd_data_o = {{(CNT_W-N_EVT){1'b0}}, flags};
            A_MASK:  rd_data_o = {{(CNT_W-N_EVT){1'b0}}, mask};
            default: rd_data_o = '0;
        endcase
    end

    // R10: interrupt rises only after a masked flag is recorded
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|set_vec) || $past(wr_mask));
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam logic [CW-1:0] MAXV = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_r = 1'b0, wr_r = 1'b0, cap_r = 1'b0;
    logic [2:0] wa_r = '0, ra_r = '0;
    logic [CW-1:0] wd_r = '0;
    logic [CW-1:0] rd_data;
    logic wave, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_r), .wr_en_i(wr_r),
        .wr_addr_i(wa_r), .wr_data_i(wd_r), .rd_addr_i(ra_r),
        .rd_data_o(rd_data), .cap_pin_i(cap_r), .wave_o(wave), .irq_o(irq)
    );

    // reference model built from the requirements
    logic [CW-1:0] m_cnt, m_cmp, m_capr;
    logic [4:0] m_ctrl;
    logic [2:0] m_flags, m_mask;
    logic m_wave, m_s1, m_s2, m_lvl;
    int m_run;

    always @(posedge clk) begin
        logic tk, ov, cm, dif, acc, ce;
        logic [2:0] clr;
        if (!rst_n) begin
            m_cnt <= '0; m_cmp <= '0; m_capr <= '0; m_ctrl <= '0;
            m_flags <= '0; m_mask <= '0; m_wave <= 1'b0;
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_lvl <= 1'b0; m_run <= 0;
        end else begin
            tk  = tick_r && !(wr_r && wa_r == 3'd1);
            ov  = tk && m_cnt == MAXV;
            cm  = tk && m_cnt == m_cmp;
            dif = m_s2 != m_lvl;
            acc = dif && (!m_ctrl[4] || m_run == 3);
            ce  = acc && (m_ctrl[3] ? !m_s2 : m_s2);
            clr = (wr_r && wa_r == 3'd4) ? wd_r[2:0] : 3'b000;
            m_run <= (dif && !acc) ? m_run + 1 : 0;
            if (acc) m_lvl <= m_s2;
            m_s1 <= cap_r;
            m_s2 <= m_s1;
            if (ce) m_capr <= m_cnt;
            if (wr_r && wa_r == 3'd1) m_cnt <= wd_r;
            else if (tk) m_cnt <= ((m_ctrl[0] && cm) || ov) ? '0 : m_cnt + 1'b1;
            if (cm) begin
                case (m_ctrl[2:1])
                    2'b01: m_wave <= ~m_wave;
                    2'b10: m_wave <= 1'b0;
                    2'b11: m_wave <= 1'b1;
                    default: ;
                endcase
            end
            m_flags <= (m_flags & ~clr) | {ce, cm, ov};
            if (wr_r && wa_r == 3'd0) m_ctrl <= wd_r[4:0];
            if (wr_r && wa_r == 3'd2) m_cmp <= wd_r;
            if (wr_r && wa_r == 3'd5) m_mask <= wd_r[2:0];
        end
    end

    function automatic logic [CW-1:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {11'b0, m_ctrl};
            3'd1: return m_cnt;
            3'd2: return m_cmp;
            3'd3: return m_capr;
            3'd4: return {13'b0, m_flags};
            3'd5: return {13'b0, m_mask};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd1: return "R1";
            3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock; outputs compared with the model at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(tag_of(ra_r), rd_data, exp_rd(ra_r));
        chk("R10", {15'b0, irq}, {15'b0, |(m_flags & m_mask)});
        chk("R5", {15'b0, wave}, {15'b0, (m_ctrl[2:1] != 2'b00) && m_wave});
        wr_r = 1'b0;
        tick_r = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_r = 1'b1; wa_r = a; wd_r = d;
        step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_r = 1'b1;
            step();
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [CW-1:0] exp, input string tag);
        ra_r = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        for (int a = 0; a < 8; a++) rd(3'(a), '0, "R12");
        chk("R12", {15'b0, irq}, 16'd0);
        chk("R12", {15'b0, wave}, 16'd0);

        // R11 then R2
        wr(3'd2, 16'h1234);
        tick_r = 1'b1; wr(3'd1, 16'hFFFE);
        rd(3'd1, 16'hFFFE, "R11");
        rd(3'd4, 16'h0000, "R11");
        ticks(1);
        rd(3'd1, 16'hFFFF, "R1");
        ticks(1);
        rd(3'd1, 16'h0000, "R2");
        rd(3'd4, 16'h0001, "R2");
        step();
        rd(3'd1, 16'h0000, "R1");

        // R3 without restart
        wr(3'd4, 16'h0007);
        wr(3'd2, 16'h0010);
        wr(3'd1, 16'h000E);
        ticks(3);
        rd(3'd1, 16'h0011, "R3");
        rd(3'd4, 16'h0002, "R3");

        // R4 restart on match
        wr(3'd4, 16'h0007);
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'h0005);
        wr(3'd1, 16'h0000);
        ticks(5);
        rd(3'd1, 16'h0005, "R4");
        ticks(1);
        rd(3'd1, 16'h0000, "R4");
        rd(3'd4, 16'h0002, "R4");

        // R5 wave modes, match every third tick
        wr(3'd2, 16'h0002);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0007);
        ticks(3); chk("R5", {15'b0, wave}, 16'd1);
        wr(3'd0, 16'h0005);
        ticks(3); chk("R5", {15'b0, wave}, 16'd0);
        wr(3'd0, 16'h0003);
        ticks(3); chk("R5", {15'b0, wave}, 16'd1);
        ticks(3); chk("R5", {15'b0, wave}, 16'd0);
        ticks(3); chk("R5", {15'b0, wave}, 16'd1);
        wr(3'd0, 16'h0001);
        chk("R5", {15'b0, wave}, 16'd0);

        // R7 filter: short glitch ignored, long pulse captured
        wr(3'd0, 16'h0010);
        wr(3'd4, 16'h0007);
        cap_r = 1'b1; step(); step();
        cap_r = 1'b0;
        for (int i = 0; i < 8; i++) step();
        rd(3'd4, 16'h0000, "R7");
        cap_r = 1'b1;
        for (int i = 0; i < 8; i++) step();
        rd(3'd4, 16'h0004, "R7");
        cap_r = 1'b0;
        for (int i = 0; i < 8; i++) step();

        // R6 falling edge, no filter, frozen count
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0042);
        wr(3'd4, 16'h0007);
        cap_r = 1'b1;
        for (int i = 0; i < 4; i++) step();
        rd(3'd4, 16'h0000, "R6");
        cap_r = 1'b0;
        for (int i = 0; i < 4; i++) step();
        rd(3'd4, 16'h0004, "R6");
        rd(3'd3, 16'h0042, "R6");

        // R9, R8, R10
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h0007);
        wr(3'd2, 16'h1000);
        wr(3'd1, 16'hFFFF);
        tick_r = 1'b1; wr(3'd4, 16'h0001);
        rd(3'd4, 16'h0001, "R9");
        wr(3'd4, 16'h0002);
        rd(3'd4, 16'h0001, "R8");
        wr(3'd5, 16'h0001);
        chk("R10", {15'b0, irq}, 16'd1);
        wr(3'd5, 16'h0006);
        chk("R10", {15'b0, irq}, 16'd0);
        wr(3'd4, 16'h0001);
        rd(3'd4, 16'h0000, "R8");

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            tick_r = ($urandom % 100) < 75;
            ra_r = 3'($urandom % 8);
            if (($urandom % 100) < 15) cap_r = ~cap_r;
            if (($urandom % 100) < 8) begin
                wr_r = 1'b1;
                wa_r = 3'($urandom % 6);
                case (wa_r)
                    3'd1: wd_r = (($urandom % 2) == 0) ? m_cmp - 16'($urandom % 4)
                                                       : MAXV - 16'($urandom % 4);
                    3'd2: wd_r = 16'($urandom % 64);
                    default: wd_r = 16'($urandom);
                endcase
            end
            step();
        end
        finish_run();
    end
endmodule